// File: doc/BRIEF.md
# Voltammetry Scan Background Averager and Subtractor

This block works on the decimated current samples of a fast-scan voltammetry recording. A scan-active timing input marks each scan. Inside that window the block counts valid samples, drops the leading ones that come before the sweep has settled, and maps the remaining ones onto a fixed set of timestamps.

After a user clear, the block adds up the samples of a selectable number of consecutive scans, one running sum per timestamp. It then freezes these sums as the averaged background. Every later scan has the averaged background of each timestamp subtracted from that timestamp's sample. The difference is saturated to 11 bits. It is then smoothed with the same timestamp's values from up to three earlier scans, which are kept in history memories. A smoothed point leaves the block one cycle after its sample arrives, together with its timestamp index. Two status flags tell whether the background is frozen and whether smoothed output is flowing.

Top module: `scan_bgsub`

## Requirements
- R1: Samples are taken only while scan_act is high, and never in the first cycle after it rises. Within a scan the first 31 samples taken are dropped, the next 96 receive timestamps 0 to 95 in order, and any further samples are ignored.
- R2: bg_mode selects how many scans are accumulated: 0 gives 4, 1 gives 8, and 2 or 3 give 16. Accumulation covers the scans that start after a clear, and each sample is added into the running sum of its timestamp.
- R3: bg_ready rises at the start of the first scan after the last accumulated scan. It then stays high, and the sums stay frozen, until the next clear.
- R4: In every scan that starts with bg_ready high, the value for timestamp i is the sample minus floor(sum_i / N), where N is the scan count from R2. The result is saturated to the range -1024 to 1023.
- R5: sm_mode selects the smoothing depth: 0 gives 1 scan, 1 gives 2 scans, and 2 or 3 give 4 scans. The output is floor of the sum of the current value and the previous scans' values for the same timestamp, divided by the depth.
- R6: sub_ready rises at the start of the scan in which the history already holds depth-1 earlier subtracted scans. out_vld is high only while sub_ready is high. out_vld pulses one cycle after each timestamped sample, and out_idx gives that sample's timestamp.
- R7: A user_clr pulse drops bg_ready and sub_ready on the next cycle, clears the sums, and captures bg_mode and sm_mode. Changes to the mode inputs at any other time have no effect.
- R8: After rst_n, out_vld, bg_ready and sub_ready are low, both captured modes are 0, and accumulation starts with the first scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| user_clr | input | 1 | Restart background acquisition and capture the modes |
| bg_mode | input | 2 | Number of background scans to accumulate |
| sm_mode | input | 2 | Smoothing depth across scans |
| scan_act | input | 1 | High for the duration of a scan |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | 14 | Signed decimated sample |
| out_vld | output | 1 | Smoothed point valid |
| out_data | output | 11 | Signed smoothed background-subtracted point |
| out_idx | output | 7 | Timestamp of out_data |
| bg_ready | output | 1 | Background frozen, subtraction active |
| sub_ready | output | 1 | Smoothed output flowing |

## Verification
The bench keeps the default parameters: 31 dropped samples, 96 timestamps, a 14-bit input and an 11-bit output. With these values it runs the true scan lengths, including a scan that carries samples past the 127th, which tests the end of the window. It covers every encoding of both modes, so it reaches the 4-, 8- and 16-scan backgrounds and every smoothing depth. Random noise, both small and large, together with directed full-scale scans, drives the saturation limits in both directions.

// File: rtl/scan_bgsub.sv
module scan_bgsub #(
  parameter int DW   = 14,
  parameter int OW   = 11,
  parameter int SKIP = 31,
  parameter int NPTS = 96,
  parameter int ACCW = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 user_clr,
  input  logic [1:0]           bg_mode,
  input  logic [1:0]           sm_mode,
  input  logic                 scan_act,
  input  logic                 smp_vld,
  input  logic signed [DW-1:0] smp_data,
  output logic                 out_vld,
  output logic signed [OW-1:0] out_data,
  output logic [$clog2(NPTS)-1:0] out_idx,
  output logic                 bg_ready,
  output logic                 sub_ready
);
  localparam int IW = $clog2(NPTS);
  localparam int CW = $clog2(SKIP + NPTS + 1);
  localparam logic [CW-1:0] CEND = CW'(SKIP + NPTS);
  localparam logic [CW-1:0] CSKIP = CW'(SKIP);
  localparam logic signed [ACCW:0] SMAX = (ACCW+1)'(2**(OW-1) - 1);
  localparam logic signed [ACCW:0] SMIN = -(ACCW+1)'(2**(OW-1));

  logic signed [ACCW-1:0] bg_mem [NPTS];
  logic signed [OW-1:0]   h0 [NPTS];
  logic signed [OW-1:0]   h1 [NPTS];
  logic signed [OW-1:0]   h2 [NPTS];

  logic          act_q, acc_now;
  logic [CW-1:0] scnt;
  logic [4:0]    acc_scans;
  logic [1:0]    hist_cnt, bgm_q, smm_q;

  wire start = scan_act & ~act_q;
  wire take  = scan_act & act_q & smp_vld;
  wire inwin = take && scnt >= CSKIP && scnt < CEND;
  wire [CW-1:0] rel = scnt - CSKIP;
  wire [IW-1:0] idx = rel[IW-1:0];

  wire [4:0] acc_need = (bgm_q == 2'd0) ? 5'd4 : (bgm_q == 2'd1) ? 5'd8 : 5'd16;
  wire [2:0] bg_sh    = (bgm_q == 2'd0) ? 3'd2 : (bgm_q == 2'd1) ? 3'd3 : 3'd4;
  wire [1:0] hist_need = (smm_q == 2'd0) ? 2'd0 : (smm_q == 2'd1) ? 2'd1 : 2'd3;
  wire [1:0] hist_nxt  = (hist_cnt == 2'd3) ? 2'd3 : hist_cnt + 2'd1;

  logic signed [ACCW-1:0] bg_avg;
  logic signed [ACCW:0]   diff;
  logic signed [OW-1:0]   cur;
  logic signed [OW+1:0]   ssum;
  logic signed [OW-1:0]   smooth;

  assign bg_avg = bg_mem[idx] >>> bg_sh;
  assign diff   = (ACCW+1)'(smp_data) - (ACCW+1)'(bg_avg);
  assign cur    = (diff > SMAX) ? SMAX[OW-1:0] : (diff < SMIN) ? SMIN[OW-1:0] : diff[OW-1:0];

  always_comb begin
    ssum = (OW+2)'(cur);
    if (smm_q != 2'd0) ssum = ssum + (OW+2)'(h0[idx]);
    if (smm_q[1])      ssum = ssum + (OW+2)'(h1[idx]) + (OW+2)'(h2[idx]);
    if (smm_q == 2'd0)      smooth = ssum[OW-1:0];
    else if (smm_q == 2'd1) smooth = ssum[OW:1];
    else                    smooth = ssum[OW+1:2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      scnt  <= '0;
    end else begin
      act_q <= scan_act;
      if (start)                   scnt <= '0;
      else if (take && scnt != CEND) scnt <= scnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bgm_q <= 2'd0; smm_q <= 2'd0;
      bg_ready <= 1'b0; sub_ready <= 1'b0; acc_now <= 1'b0;
      acc_scans <= '0; hist_cnt <= '0;
    end else if (user_clr) begin
      bgm_q <= bg_mode; smm_q <= sm_mode;
      bg_ready <= 1'b0; sub_ready <= 1'b0; acc_now <= 1'b0;
      acc_scans <= '0; hist_cnt <= '0;
    end else if (start) begin
      if (!bg_ready) begin
        if (acc_scans == acc_need) begin
          bg_ready <= 1'b1;
          acc_now  <= 1'b0;
          hist_cnt <= 2'd0;
          if (hist_need == 2'd0) sub_ready <= 1'b1;
        end else begin
          acc_now   <= 1'b1;
          acc_scans <= acc_scans + 5'd1;
        end
      end else begin
        acc_now  <= 1'b0;
        hist_cnt <= hist_nxt;
        if (hist_nxt >= hist_need) sub_ready <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPTS; i++) bg_mem[i] <= '0;
    end else if (user_clr) begin
      for (int i = 0; i < NPTS; i++) bg_mem[i] <= '0;
    end else if (inwin && acc_now) begin
      bg_mem[idx] <= bg_mem[idx] + ACCW'(smp_data);
    end
  end

  always_ff @(posedge clk) begin
    if (inwin && bg_ready && !user_clr) begin
      h0[idx] <= cur;
      h1[idx] <= h0[idx];
      h2[idx] <= h1[idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_data <= '0;
      out_idx  <= '0;
    end else begin
      out_vld <= inwin && sub_ready && !user_clr;
      if (inwin) begin
        out_data <= smooth;
        out_idx  <= idx;
      end
    end
  end

  a_r6_out_needs_sub: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (sub_ready && bg_ready));
  a_r1_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (int'(out_idx) < NPTS));
  a_r3_bg_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bg_ready) |-> $past(start));
  a_r6_sub_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sub_ready) |-> $past(start));
  a_r7_clear_drops_flags: assert property (@(posedge clk) disable iff (!rst_n)
    user_clr |=> (!bg_ready && !sub_ready && !out_vld));
  a_r3_fall_only_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bg_ready) |-> $past(user_clr));
  a_r3_frozen_while_ready: assert property (@(posedge clk) disable iff (!rst_n)
    acc_now |-> !bg_ready);
endmodule

// File: tb/scan_bgsub_test.sv
module scan_bgsub_test;
  localparam int CLK_PERIOD = 10;
  localparam int NPTS = 96;
  localparam int SKIP = 31;

  logic clk = 1'b0, rst_n = 1'b0, user_clr = 1'b0, scan_act = 1'b0, smp_vld = 1'b0;
  logic [1:0] bg_mode = 2'd0, sm_mode = 2'd0;
  logic signed [13:0] smp_data = '0;
  logic out_vld, bg_ready, sub_ready;
  logic signed [10:0] out_data;
  logic [6:0] out_idx;

  scan_bgsub uut (.clk(clk), .rst_n(rst_n), .user_clr(user_clr), .bg_mode(bg_mode),
    .sm_mode(sm_mode), .scan_act(scan_act), .smp_vld(smp_vld), .smp_data(smp_data),
    .out_vld(out_vld), .out_data(out_data), .out_idx(out_idx),
    .bg_ready(bg_ready), .sub_ready(sub_ready));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit m_bgr, m_sub, m_accn;
  int m_accs, m_hc, m_bgm, m_smm;
  int bgsum [NPTS];
  int hs0 [NPTS], hs1 [NPTS], hs2 [NPTS];
  int base [NPTS];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat11(input int v);
    return v > 1023 ? 1023 : (v < -1024 ? -1024 : v);
  endfunction
  function automatic int clamp14(input int v);
    return v > 8191 ? 8191 : (v < -8192 ? -8192 : v);
  endfunction
  function automatic int rnd(input int lim);
    return int'($urandom % (2*lim + 1)) - lim;
  endfunction
  function automatic int need_n();
    return m_bgm == 0 ? 4 : (m_bgm == 1 ? 8 : 16);
  endfunction
  function automatic int need_sh();
    return m_bgm == 0 ? 2 : (m_bgm == 1 ? 3 : 4);
  endfunction
  function automatic int need_h();
    return m_smm == 0 ? 0 : (m_smm == 1 ? 1 : 3);
  endfunction

  task automatic model_start();
    if (!m_bgr) begin
      if (m_accs == need_n()) begin
        m_bgr = 1; m_accn = 0; m_hc = 0;
        if (need_h() == 0) m_sub = 1;
      end else begin
        m_accn = 1; m_accs++;
      end
    end else begin
      m_accn = 0;
      if (m_hc < 3) m_hc++;
      if (m_hc >= need_h()) m_sub = 1;
    end
  endtask

  task automatic do_clear(input int bm, input int sm);
    @(negedge clk);
    user_clr = 1'b1; bg_mode = 2'(bm); sm_mode = 2'(sm);
    @(negedge clk);
    user_clr = 1'b0;
    bg_mode = ~bg_mode; sm_mode = ~sm_mode;
    m_bgm = bm; m_smm = sm; m_bgr = 0; m_sub = 0; m_accn = 0; m_accs = 0; m_hc = 0;
    for (int i = 0; i < NPTS; i++) begin bgsum[i] = 0; base[i] = rnd(3000); end
    chk(bg_ready == 1'b0, "R7 bg_ready after clear", int'(bg_ready), 0);
    chk(sub_ready == 1'b0, "R7 sub_ready after clear", int'(sub_ready), 0);
  endtask

  // mode: 0 small noise, 1 large noise, 2 full-scale high, 3 full-scale low
  task automatic run_scan(input int nsamp, input int mode, input bit early);
    int d, i, sh, avg, cur, exp, v;
    @(negedge clk);
    scan_act = 1'b1;
    if (early) begin smp_vld = 1'b1; smp_data = 14'sh1FFF; end
    model_start();
    @(negedge clk);
    smp_vld = 1'b0;
    chk(bg_ready == m_bgr, "R3 bg_ready at scan start", int'(bg_ready), int'(m_bgr));
    chk(sub_ready == m_sub, "R6 sub_ready at scan start", int'(sub_ready), int'(m_sub));
    for (int k = 0; k < nsamp; k++) begin
      if (mode == 2) d = 8191;
      else if (mode == 3) d = -8192;
      else d = clamp14((k >= SKIP && k < SKIP + NPTS ? base[k-SKIP] : 0) + rnd(mode == 1 ? 4000 : 200));
      @(negedge clk);
      smp_vld = 1'b1; smp_data = 14'(d);
      v = 0; exp = 0; i = k - SKIP;
      if (i >= 0 && i < NPTS) begin
        if (m_accn) bgsum[i] += d;
        if (m_bgr) begin
          sh = need_sh();
          avg = bgsum[i] >>> sh;
          cur = sat11(d - avg);
          if (m_sub) begin
            v = 1;
            if (m_smm == 0) exp = cur;
            else if (m_smm == 1) exp = (cur + hs0[i]) >>> 1;
            else exp = (cur + hs0[i] + hs1[i] + hs2[i]) >>> 2;
          end
          hs2[i] = hs1[i]; hs1[i] = hs0[i]; hs0[i] = cur;
        end
      end
      @(negedge clk);
      smp_vld = 1'b0;
      chk(out_vld == v, "R1 R6 out_vld per sample", int'(out_vld), v);
      if (v) begin
        chk(int'(out_idx) == i, "R1 timestamp index", int'(out_idx), i);
        chk(int'(out_data) == exp, "R4 R5 smoothed difference", int'(out_data), exp);
      end
      if (($urandom % 4) == 0) @(negedge clk);
    end
    @(negedge clk);
    scan_act = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_bgm = 0; m_smm = 0; m_bgr = 0; m_sub = 0; m_accn = 0; m_accs = 0; m_hc = 0;
    for (int i = 0; i < NPTS; i++) begin bgsum[i] = 0; base[i] = rnd(3000); end
    repeat (3) @(negedge clk);
    chk(out_vld == 1'b0 && bg_ready == 1'b0 && sub_ready == 1'b0, "R8 reset state",
        int'({out_vld, bg_ready, sub_ready}), 0);
    rst_n = 1'b1;
    bg_mode = 2'd3; sm_mode = 2'd3;
    // R8 default modes: 4-scan background, no smoothing
    for (int s = 0; s < 4; s++) run_scan(127, 0, 1'b0);
    run_scan(127, 0, 1'b0);
    run_scan(127, 1, 1'b0);
    run_scan(127, 2, 1'b0);
    // R2 R5 mode 1: 8 scans, depth 2; R1 early sample and overlong scan
    do_clear(1, 1);
    for (int s = 0; s < 8; s++) run_scan(127, 0, s == 2);
    run_scan(127, 0, 1'b1);
    run_scan(130, 1, 1'b0);
    run_scan(127, 3, 1'b0);
    run_scan(127, 0, 1'b0);
    // R2 R5 mode 2: 16 scans, depth 4
    do_clear(2, 2);
    for (int s = 0; s < 16; s++) run_scan(127, 0, 1'b0);
    for (int s = 0; s < 5; s++) run_scan(127, s == 4 ? 2 : 1, 1'b0);
    // R2 R5 mode 3 aliases
    do_clear(3, 3);
    for (int s = 0; s < 16; s++) run_scan(127, 1, 1'b0);
    for (int s = 0; s < 5; s++) run_scan(127, s == 3 ? 3 : 0, 1'b0);
    // R7 clear mid-run with a short, interrupted second setup
    do_clear(0, 2);
    for (int s = 0; s < 2; s++) run_scan(127, 0, 1'b0);
    do_clear(0, 2);
    for (int s = 0; s < 4; s++) run_scan(127, 0, 1'b0);
    for (int s = 0; s < 5; s++) run_scan(127, s == 1 ? 1 : 0, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule